// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block takes a single-rank, 32-bit-wide SDRAM from power-on to a usable state and then keeps it refreshed. After reset it holds the command bus at NOP for a programmable settling time. It then issues a fixed sequence: precharge-all, a first mode-register load, two groups of four auto-refreshes, and a second mode-register load. The mode load is repeated after the refreshes because some devices only accept it once the refreshes are done. Ten dummy access slots follow to let the device settle, and only then does the block raise `ready`.

Once ready, a timer built from a period count and a prescaler raises a refresh request. The surrounding controller grants the request when it is between bursts, so a refresh never cuts into a transfer. The block then runs four auto-refreshes on its own command outputs and returns to ready. A slow-rate input doubles the prescaler, which halves the refresh rate for smaller memories. Time is counted in clock cycles, derived from the clock frequency and the microsecond figures given as parameters.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `cmd` is NOP (code 0), `addr` is 0, and `ready` and `ref_req` are 0.
- R2: After reset is released, only NOP appears for PWRUP_US*CLK_MHZ cycles. The precharge-all (code 1) appears exactly that many cycles after release.
- R3: The initialisation commands appear in this order: precharge-all (1), mode load (3), eight auto-refreshes (2), mode load (3), and ten dummy access slots (4). That is 21 commands in total.
- R4: Consecutive refreshes inside a group of four are RFC_CYC+1 cycles apart. Any other pair of consecutive initialisation commands is GAP_US*CLK_MHZ+1 cycles apart. The ten dummy slots occupy consecutive cycles.
- R5: During a mode load, `addr` carries MODE_WORD shifted left by two (0x88 for the default 0x22: burst length 4, sequential, CAS latency 2). During any other command or NOP, `addr` is 0.
- R6: `ready` rises in the cycle after the last dummy slot. While `ready` is high, `cmd` is NOP.
- R7: `ref_req` stays low until `ready` has risen. It first rises exactly REF_PERIOD*PRESC_FAST cycles after `ready` rises with `slow_rate` low, and exactly twice that many cycles with `slow_rate` high.
- R8: `ref_req` stays high until `ref_ack` is sampled high while `ready` is high. In the next cycle `ref_req` is low, `ready` is low and `cmd` is an auto-refresh. Four auto-refreshes follow, RFC_CYC+1 cycles apart, and `ready` returns 4*(RFC_CYC+1) cycles after the first of them.
- R9: A `ref_ack` pulse while `ref_req` is low is ignored: `ready` stays high and `cmd` stays NOP.
- R10: The refresh timer runs freely from the rise of `ready`. It is not restarted by a grant, so the second request rises exactly two periods after `ready` first rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_rate | input | 1 | 1 doubles the refresh prescaler; hold steady while running |
| ref_ack | input | 1 | Grant from the controller for a pending refresh |
| cmd | output | 3 | Command code: 0 NOP, 1 precharge-all, 2 auto-refresh, 3 mode load, 4 dummy slot |
| addr | output | ADDR_W | Address lines; carry the shifted mode word during a mode load |
| ready | output | 1 | Device initialised and idle; controller may issue accesses |
| ref_req | output | 1 | Refresh pending; cleared by a grant |

## Verification
A step counter that skips or repeats a state shows up at the ports at once. The next non-NOP command carries the wrong code, or it arrives at the wrong distance from the one before, so the error is visible within one gap time of the fault. A wrong mode word is visible in the very cycle of the mode load.

The refresh timer has no port of its own. A prescaler or period error therefore shows only when `ref_req` rises early or late, up to one full period (about 3,120 cycles in slow mode) after `ready`. A timer that restarts on a grant shows one period later, on the second request.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

   typedef enum logic [2:0] {
      CMD_NOP  = 3'd0,
      CMD_PRE  = 3'd1,
      CMD_REF  = 3'd2,
      CMD_MRS  = 3'd3,
      CMD_SLOT = 3'd4
   } sdr_cmd_e;

   typedef enum logic [1:0] {
      PH_PWR,
      PH_ISSUE,
      PH_WAIT,
      PH_RUN
   } seq_phase_e;

   typedef enum logic [1:0] {
      WK_NONE,
      WK_GAP,
      WK_RFC
   } wait_kind_e;

   localparam int          STEP_W      = 5;
   localparam logic [4:0]  LAST_INIT   = 5'd20;
   localparam logic [4:0]  FIRST_BURST = 5'd21;
   localparam logic [4:0]  LAST_BURST  = 5'd24;

   // Command issued in each step. Steps 0..20 form the start-up
   // program; steps 21..24 form the periodic refresh burst.
   function automatic sdr_cmd_e step_cmd(input logic [4:0] s);
      sdr_cmd_e c;
      if (s == 5'd0)                     c = CMD_PRE;
      else if (s == 5'd1 || s == 5'd10)  c = CMD_MRS;
      else if (s >= 5'd2 && s <= 5'd9)   c = CMD_REF;
      else if (s >= 5'd11 && s <= 5'd20) c = CMD_SLOT;
      else if (s >= 5'd21 && s <= 5'd24) c = CMD_REF;
      else                               c = CMD_NOP;
      return c;
   endfunction

   // Kind of NOP stretch that follows each step.
   function automatic wait_kind_e step_wait(input logic [4:0] s);
      wait_kind_e k;
      if (s == 5'd0 || s == 5'd1 || s == 5'd5 || s == 5'd9 || s == 5'd10)
         k = WK_GAP;
      else if ((s >= 5'd2 && s <= 5'd4) || (s >= 5'd6 && s <= 5'd8) ||
               (s >= 5'd21 && s <= 5'd24))
         k = WK_RFC;
      else
         k = WK_NONE;
      return k;
   endfunction

endpackage

// File: rtl/sdr_step_seq.sv
module sdr_step_seq
   import sdr_seq_pkg::*;
#(
   parameter int PWRUP_CYC = 10000,
   parameter int GAP_CYC   = 100,
   parameter int RFC_CYC   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_go,
   output logic [2:0] cmd_o,
   output logic       run_o,
   output logic       init_done_o
);

   localparam int MAX_A = (PWRUP_CYC > GAP_CYC) ? PWRUP_CYC : GAP_CYC;
   localparam int MAX_W = (MAX_A > RFC_CYC) ? MAX_A : RFC_CYC;
   localparam int CNT_W = (MAX_W < 2) ? 1 : $clog2(MAX_W + 1);

   seq_phase_e       phase_q;
   logic [4:0]       step_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q;
   logic [CNT_W-1:0] wlen;

   always_comb begin
      case (step_wait(step_q))
         WK_GAP:  wlen = CNT_W'(GAP_CYC);
         WK_RFC:  wlen = CNT_W'(RFC_CYC);
         default: wlen = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_PWR;
         step_q  <= '0;
         cnt_q   <= CNT_W'(PWRUP_CYC - 1);
         done_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_PWR: begin
               if (cnt_q == '0) phase_q <= PH_ISSUE;
               else             cnt_q   <= cnt_q - 1'b1;
            end
            PH_ISSUE, PH_WAIT: begin
               if (phase_q == PH_ISSUE && wlen != '0) begin
                  phase_q <= PH_WAIT;
                  cnt_q   <= wlen - 1'b1;
               end else if (phase_q == PH_WAIT && cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (step_q == LAST_INIT) begin
                  phase_q <= PH_RUN;
                  done_q  <= 1'b1;
               end else if (step_q == LAST_BURST) begin
                  phase_q <= PH_RUN;
               end else begin
                  phase_q <= PH_ISSUE;
                  step_q  <= step_q + 1'b1;
               end
            end
            default: begin
               if (ref_go) begin
                  phase_q <= PH_ISSUE;
                  step_q  <= FIRST_BURST;
               end
            end
         endcase
      end
   end

   assign cmd_o       = (phase_q == PH_ISSUE) ? step_cmd(step_q) : CMD_NOP;
   assign run_o       = (phase_q == PH_RUN);
   assign init_done_o = done_q;

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
   parameter int REF_PERIOD = 195,
   parameter int PRESC_FAST = 8,
   parameter bit SLOW_EN    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slow,
   output logic tick
);

   localparam int P_W = (2 * PRESC_FAST < 2) ? 1 : $clog2(2 * PRESC_FAST);
   localparam int Q_W = (REF_PERIOD < 2) ? 1 : $clog2(REF_PERIOD);

   logic [P_W-1:0] p_q;
   logic [Q_W-1:0] q_q;
   logic [P_W-1:0] p_lim;
   logic           p_wrap;
   logic           q_wrap;

   generate
      if (SLOW_EN) begin : g_dual_rate
         assign p_lim = slow ? P_W'(2 * PRESC_FAST - 1) : P_W'(PRESC_FAST - 1);
      end else begin : g_fixed_rate
         assign p_lim = slow ? P_W'(PRESC_FAST - 1) : P_W'(PRESC_FAST - 1);
      end
   endgenerate

   assign p_wrap = (p_q >= p_lim);
   assign q_wrap = (q_q == Q_W'(REF_PERIOD - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         p_q <= '0;
         q_q <= '0;
      end else if (p_wrap) begin
         p_q <= '0;
         q_q <= q_wrap ? '0 : q_q + 1'b1;
      end else begin
         p_q <= p_q + 1'b1;
      end
   end

   assign tick = en && p_wrap && q_wrap;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdr_seq_pkg::*;
#(
   parameter int              CLK_MHZ    = 50,
   parameter int              PWRUP_US   = 200,
   parameter int              GAP_US     = 2,
   parameter int              RFC_CYC    = 4,
   parameter int              REF_PERIOD = 195,
   parameter int              PRESC_FAST = 8,
   parameter bit              SLOW_EN    = 1'b1,
   parameter int              ADDR_W     = 13,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slow_rate,
   input  logic              ref_ack,
   output logic [2:0]        cmd,
   output logic [ADDR_W-1:0] addr,
   output logic              ready,
   output logic              ref_req
);

   localparam int PWRUP_CYC = PWRUP_US * CLK_MHZ;
   localparam int GAP_CYC   = GAP_US * CLK_MHZ;

   generate
      if (PWRUP_CYC < 1)   begin : g_bad_pwrup  $error("power-up time must be at least one cycle"); end
      if (REF_PERIOD < 1)  begin : g_bad_period $error("refresh period must be positive"); end
      if (PRESC_FAST < 1)  begin : g_bad_presc  $error("prescaler must be positive"); end
      if (ADDR_W < 3)      begin : g_bad_addr   $error("address too narrow for mode word"); end
      if ((MODE_WORD >> (ADDR_W - 2)) != 0) begin : g_bad_mode
         $error("mode word does not fit after the two-bit shift");
      end
   endgenerate

   logic [2:0] seq_cmd;
   logic       run;
   logic       init_done;
   logic       tick;
   logic       accept;
   logic       req_q;

   assign accept = run && req_q && ref_ack;

   sdr_step_seq #(
      .PWRUP_CYC (PWRUP_CYC),
      .GAP_CYC   (GAP_CYC),
      .RFC_CYC   (RFC_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .ref_go      (accept),
      .cmd_o       (seq_cmd),
      .run_o       (run),
      .init_done_o (init_done)
   );

   sdr_ref_timer #(
      .REF_PERIOD (REF_PERIOD),
      .PRESC_FAST (PRESC_FAST),
      .SLOW_EN    (SLOW_EN)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (init_done),
      .slow  (slow_rate),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      req_q <= 1'b0;
      else if (tick)   req_q <= 1'b1;
      else if (accept) req_q <= 1'b0;
   end

   assign cmd     = seq_cmd;
   assign addr    = (seq_cmd == CMD_MRS) ? (MODE_WORD << 2) : '0;
   assign ready   = run;
   assign ref_req = req_q;

endmodule

// File: rtl/sdr_pwrup_chk.sv
module sdr_pwrup_chk #(
   parameter int                PWRUP_CYC = 10000,
   parameter int                ADDR_W    = 13,
   parameter logic [ADDR_W-1:0] MODE_WORD = 'h22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ref_ack,
   input logic [2:0]        cmd,
   input logic [ADDR_W-1:0] addr,
   input logic              ready,
   input logic              ref_req
);

   int   cyc_q;
   logic seen_ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cyc_q        <= 0;
         seen_ready_q <= 1'b0;
      end else begin
         if (cyc_q < PWRUP_CYC) cyc_q <= cyc_q + 1;
         if (ready) seen_ready_q <= 1'b1;
      end
   end

   p_quiet_pwrup_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q < PWRUP_CYC) |-> (cmd == 3'd0));

   p_mode_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 3'd3) |-> (addr == (MODE_WORD << 2)));

   p_idle_when_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (cmd == 3'd0));

   p_no_early_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_ready_q |-> !ref_req);

   p_req_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_ack) |=> ref_req);

   p_grant_starts_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && ref_req && ref_ack) |=> (cmd == 3'd2 && !ready && !ref_req));

   p_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !ref_req && ref_ack) |=> ready);

endmodule

bind sdram_pwrup_seq sdr_pwrup_chk #(
   .PWRUP_CYC (PWRUP_US * CLK_MHZ),
   .ADDR_W    (ADDR_W),
   .MODE_WORD (MODE_WORD)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ref_ack (ref_ack),
   .cmd     (cmd),
   .addr    (addr),
   .ready   (ready),
   .ref_req (ref_req)
);

// File: tb/sim_sdram_pwrup_seq.sv
module sim_sdram_pwrup_seq;

   localparam int CLK_PERIOD = 20;
   localparam int MHZ   = 50;
   localparam int PW_US = 20;
   localparam int GP_US = 2;
   localparam int RFC   = 4;
   localparam int PER   = 195;
   localparam int PF    = 8;
   localparam int AW    = 13;
   localparam int P     = PW_US * MHZ;
   localparam int G     = GP_US * MHZ;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          slow_rate = 1'b0;
   logic          ref_ack = 1'b0;
   logic [2:0]    cmd;
   logic [AW-1:0] addr;
   logic          ready;
   logic          ref_req;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;
   int  n;

   sdram_pwrup_seq #(
      .CLK_MHZ    (MHZ),
      .PWRUP_US   (PW_US),
      .GAP_US     (GP_US),
      .RFC_CYC    (RFC),
      .REF_PERIOD (PER),
      .PRESC_FAST (PF),
      .SLOW_EN    (1'b1),
      .ADDR_W     (AW),
      .MODE_WORD  (13'h22)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_rate (slow_rate),
      .ref_ack   (ref_ack),
      .cmd       (cmd),
      .addr      (addr),
      .ready     (ready),
      .ref_req   (ref_req)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_code(input int k);
      if (k == 0)             return 1;
      if (k == 1 || k == 10)  return 3;
      if (k >= 2 && k <= 9)   return 2;
      return 4;
   endfunction

   function automatic int exp_space(input int k);
      if ((k >= 2 && k <= 4) || (k >= 6 && k <= 8)) return RFC + 1;
      if (k >= 11) return 1;
      return G + 1;
   endfunction

   function automatic int period_cycles(input bit slow);
      return PER * (slow ? 2 * PF : PF);
   endfunction

   task automatic step();
      @(negedge clk);
      n++;
   endtask

   task automatic run_case(input bit slow, input int dly);
      int codes [32];
      int times [32];
      int addrs [32];
      int idx = 0;
      int nready = -1;
      int early = 0;
      int bad = 0;
      int a;
      int nref;
      int t_per;
      bit spacing_ok;
      t_per = period_cycles(slow);
      rst_n = 1'b0;
      slow_rate = slow;
      ref_ack = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cmd == 3'd0 && addr == '0 && !ready && !ref_req, "R1 reset outputs",
            {cmd, ready, ref_req}, 0);
      rst_n = 1'b1;
      n = 0;
      while (nready < 0 && n < P + 5000) begin
         if (ready) nready = n;
         else begin
            if (ref_req) early++;
            if (cmd != 3'd0) begin
               if (idx < 32) begin
                  codes[idx] = int'(cmd);
                  times[idx] = n;
                  addrs[idx] = int'(addr);
               end
               idx++;
            end
         end
         step();
      end
      check(idx == 21, "R3 command count", idx, 21);
      check(idx > 0 && times[0] == P, "R2 first command time", times[0], P);
      check(idx > 0 && codes[0] == 1, "R2 first command is precharge", codes[0], 1);
      if (idx == 21) begin
         for (int k = 0; k < 21; k++) begin
            check(codes[k] == exp_code(k), "R3 command order", codes[k], exp_code(k));
            check(addrs[k] == ((codes[k] == 3) ? 32'h88 : 0), "R5 address lines",
                  addrs[k], (codes[k] == 3) ? 32'h88 : 0);
         end
         spacing_ok = 1'b1;
         for (int k = 0; k < 20; k++) begin
            if (times[k + 1] - times[k] != exp_space(k)) begin
               spacing_ok = 1'b0;
               check(1'b0, "R4 command spacing", times[k + 1] - times[k], exp_space(k));
            end
         end
         check(spacing_ok, "R4 all spacings", 0, 0);
         check(nready == times[20] + 1, "R6 ready timing", nready, times[20] + 1);
      end
      check(early == 0, "R7 no request before ready", early, 0);
      // R9: stray grant while nothing is pending
      ref_ack = 1'b1;
      step();
      ref_ack = 1'b0;
      check(ready && cmd == 3'd0, "R9 stray grant ignored", {cmd, ready}, 1);
      while (!ref_req && n < nready + t_per + 10) begin
         if (!ready || cmd != 3'd0) bad++;
         step();
      end
      check(bad == 0, "R6 idle while ready", bad, 0);
      check(n == nready + t_per, "R7 first request time", n - nready, t_per);
      bad = 0;
      for (int i = 0; i < dly; i++) begin
         step();
         if (!ref_req) bad++;
      end
      check(bad == 0, "R8 request held until grant", bad, 0);
      ref_ack = 1'b1;
      step();
      ref_ack = 1'b0;
      a = n;
      check(cmd == 3'd2 && !ready && !ref_req, "R8 grant starts burst",
            {cmd, ready, ref_req}, 8);
      nref = 1;
      bad = 0;
      while (!ready && n < a + 100) begin
         step();
         if (cmd == 3'd2) begin
            if (n != a + nref * (RFC + 1)) bad++;
            nref++;
         end else if (cmd != 3'd0) bad++;
      end
      check(nref == 4 && bad == 0, "R8 four refreshes spaced", nref, 4);
      check(n == a + 4 * (RFC + 1), "R8 ready returns", n - a, 4 * (RFC + 1));
      while (!ref_req && n < nready + 2 * t_per + 10) step();
      check(n == nready + 2 * t_per, "R10 second request time", n - nready, 2 * t_per);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

   initial begin
      void'($urandom(32'd1234));
      run_case(1'b0, 0);
      run_case(1'b1, 0);
      run_case(1'b0, 40);
      for (int r = 0; r < 3; r++) begin
         run_case(1'($urandom_range(0, 1)), int'($urandom_range(0, 30)));
      end
      finish_run();
   end

endmodule